// File: doc/BRIEF.md
# SDRAM Bank Command Legality Tracker

This block watches the command bus of a four-bank synchronous DRAM and follows what each bank is doing. On every rising clock edge it decodes chip select, the three command strobes, the bank address and the auto-precharge address bit. It then advances a small state machine per bank through opening, open, bursting, write recovery, closing and auto-close phases. Each phase is timed by a per-bank down-counter whose lengths come from parameters in clock cycles.

Every command is judged against the current state of the bank it targets and, where relevant, of all banks together. The checks cover activate spacing, the minimum time a row stays open, refresh and mode-set windows, and auto-precharge lockout. A command that breaks a rule raises a one-cycle error pulse with a cause code, and it leaves every state and counter as if it had not been issued. The tracker is meant for a memory-controller verification environment, or as an on-chip protocol guard. It never drives the bus.

All timing parameters and the burst length must be at least 2. The bank count must be a power of two.

Top module: `sdcmd_tracker`

## Requirements
- R1: Commands are decoded from {cs_n,ras_n,cas_n,we_n}: cs_n high is deselect and does nothing; 0111 no-op, 0110 burst stop, 0101 read, 0100 write, 0011 activate, 0010 precharge, 0001 refresh, 0000 mode set. After reset every bank reports state 0 (idle), all_idle_o is 1 and err_o is 0.
- R2: Bank state codes are 0 idle, 1 opening, 2 open, 3 reading, 4 writing, 5 write recovery, 6 closing, 7 auto-close. An activate to an idle bank shows 1 and reports 2 from the edge T_RCD cycles after it. A read or write before that edge gets error code 1.
- R3: A read or write to a bank that is not open (states 0, 1 or 6) gets code 1. An accepted read shows 3 and returns to 2 BURST edges after the command. A write shows 4, then 5 for exactly one cycle, then 2 from the edge BURST+1 after the command.
- R4: An activate to a bank that is not idle gets code 2.
- R5: A read or write with ap high puts the bank in state 7. The bank becomes idle BURST+T_RP edges after a read, or BURST+1+T_RP edges after a write. Until then every command touching it gets code 2: burst stop, single or all-bank precharge, read, write and activate.
- R6: A precharge with ap low closes the bank on ba: state 6, then idle from the edge T_RP after it. A precharge to an idle or closing bank is accepted and changes nothing.
- R7: A precharge with ap high ignores ba and closes every open bank. If any bank would violate a rule, it gets code 2 or 4 and no bank changes.
- R8: A precharge that comes earlier than T_RAS edges after the bank's activate, or that finds the bank opening or in write recovery, gets code 4.
- R9: An activate fewer than T_RRD edges after the previous accepted activate gets code 4.
- R10: Refresh or mode set while any bank is not idle gets code 3. Accepted, they drop all_idle_o for T_RC cycles (refresh) or 2 cycles (mode set). In that window every command other than no-op or deselect gets code 4.
- R11: Burst stop moves every reading or writing bank to open (2) at once, with no write recovery.
- R12: Error codes are 1 bank not open, 2 bank busy, 3 banks not all idle, 4 timing. err_o and err_code_o are valid for one cycle, in the cycle after the offending edge. A rejected command changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write strobe, low active |
| ba | input | $clog2(NUM_BANKS) | Bank address |
| ap | input | 1 | Auto-precharge / precharge-all address bit |
| bank_state_o | output | NUM_BANKS*3 | State code of bank n in bits 3n+2:3n |
| all_idle_o | output | 1 | Every bank idle and no refresh/mode-set window running |
| err_o | output | 1 | One-cycle illegal-command pulse |
| err_code_o | output | 3 | Cause of the pulse, 0 when quiet |

## Verification
Two kinds of event can land on the same clock edge: a bank's timed phase ending on its own, and a command arriving that is judged against that phase. The bench drives the boundary case directly. A precharge is issued on the edge where write recovery ends, so it must be rejected while the bank still moves to open. A precharge-all is issued while one bank is still inside its minimum open time, so the other, legal bank must stay open. The auto-close countdowns are also probed with a string of rejected commands, to confirm that errors neither stall nor restart the counters.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [2:0] {
        BS_IDLE    = 3'd0,
        BS_OPENING = 3'd1,
        BS_OPEN    = 3'd2,
        BS_RD      = 3'd3,
        BS_WR      = 3'd4,
        BS_WREC    = 3'd5,
        BS_CLOSING = 3'd6,
        BS_AUTOCL  = 3'd7
    } bank_state_t;

    typedef enum logic [2:0] {
        E_NONE     = 3'd0,
        E_NOT_OPEN = 3'd1,
        E_BUSY     = 3'd2,
        E_NOT_IDLE = 3'd3,
        E_TIMING   = 3'd4
    } err_t;

    typedef enum logic [2:0] {
        CM_NOP, CM_BST, CM_RD, CM_WR, CM_ACT, CM_PRE, CM_REF, CM_MRS
    } cmd_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_ACT, OP_RD, OP_WR, OP_RDA, OP_WRA, OP_PRE, OP_STOP
    } bop_t;

    typedef struct packed {
        cmd_t cmd;
        logic ap;
    } dcmd_t;

    function automatic cmd_t decode_pins(logic cs_n, logic ras_n, logic cas_n, logic we_n);
        cmd_t c;
        if (cs_n) begin
            c = CM_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  c = CM_NOP;
                3'b110:  c = CM_BST;
                3'b101:  c = CM_RD;
                3'b100:  c = CM_WR;
                3'b011:  c = CM_ACT;
                3'b010:  c = CM_PRE;
                3'b001:  c = CM_REF;
                default: c = CM_MRS;
            endcase
        end
        return c;
    endfunction

    // Banks that accept a column command
    function automatic logic is_open(bank_state_t s);
        return (s == BS_OPEN) || (s == BS_RD) || (s == BS_WR) || (s == BS_WREC);
    endfunction

    // Banks that a precharge actually closes
    function automatic logic pre_needed(bank_state_t s);
        return (s == BS_OPEN) || (s == BS_RD) || (s == BS_WR);
    endfunction

    function automatic err_t pre_check(bank_state_t s, logic ras_done);
        err_t e;
        case (s)
            BS_AUTOCL:                 e = E_BUSY;
            BS_OPENING, BS_WREC:       e = E_TIMING;
            BS_OPEN, BS_RD, BS_WR:     e = ras_done ? E_NONE : E_TIMING;
            default:                   e = E_NONE;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic  cs_n,
    input  logic  ras_n,
    input  logic  cas_n,
    input  logic  we_n,
    input  logic  ap,
    output dcmd_t dc
);
    always_comb begin
        dc.cmd = decode_pins(cs_n, ras_n, cas_n, we_n);
        dc.ap  = ap;
    end
endmodule

// File: rtl/sdcmd_judge.sv
module sdcmd_judge
    import sdcmd_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BA_W = 2
) (
    input  dcmd_t                  dc,
    input  logic [BA_W-1:0]        ba,
    input  bank_state_t [NB-1:0]   st,
    input  logic [NB-1:0]          ras_done,
    input  logic                   rrd_ok,
    input  logic                   dev_ok,
    output err_t                   err,
    output bop_t [NB-1:0]          op
);
    logic        any_auto;
    logic        every_idle;
    logic        pall_timing;
    bank_state_t sel;

    always_comb begin
        any_auto    = 1'b0;
        every_idle  = 1'b1;
        pall_timing = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (st[b] == BS_AUTOCL) any_auto = 1'b1;
            if (st[b] != BS_IDLE) every_idle = 1'b0;
            if (pre_check(st[b], ras_done[b]) == E_TIMING) pall_timing = 1'b1;
        end
    end

    assign sel = st[ba];

    always_comb begin
        err = E_NONE;
        for (int b = 0; b < NB; b++) op[b] = OP_NONE;
        if (dc.cmd != CM_NOP && !dev_ok) begin
            err = E_TIMING;
        end else begin
            case (dc.cmd)
                CM_BST: begin
                    if (any_auto) err = E_BUSY;
                    else begin
                        for (int b = 0; b < NB; b++)
                            if (st[b] == BS_RD || st[b] == BS_WR) op[b] = OP_STOP;
                    end
                end
                CM_RD, CM_WR: begin
                    if (sel == BS_AUTOCL) err = E_BUSY;
                    else if (!is_open(sel)) err = E_NOT_OPEN;
                    else if (dc.cmd == CM_RD) begin
                        if (dc.ap) op[ba] = OP_RDA;
                        else       op[ba] = OP_RD;
                    end else begin
                        if (dc.ap) op[ba] = OP_WRA;
                        else       op[ba] = OP_WR;
                    end
                end
                CM_ACT: begin
                    if (sel != BS_IDLE) err = E_BUSY;
                    else if (!rrd_ok)   err = E_TIMING;
                    else                op[ba] = OP_ACT;
                end
                CM_PRE: begin
                    if (dc.ap) begin
                        if (any_auto)         err = E_BUSY;
                        else if (pall_timing) err = E_TIMING;
                        else begin
                            for (int b = 0; b < NB; b++)
                                if (pre_needed(st[b])) op[b] = OP_PRE;
                        end
                    end else begin
                        err = pre_check(sel, ras_done[ba]);
                        if (err == E_NONE && pre_needed(sel)) op[ba] = OP_PRE;
                    end
                end
                CM_REF, CM_MRS: begin
                    if (!every_idle) err = E_NOT_IDLE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
    import sdcmd_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_RCD = 3,
    parameter int T_RAS = 5,
    parameter int BURST = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  bop_t        op,
    output bank_state_t st,
    output logic        ras_done
);
    localparam int LONG = BURST + T_RP + T_RCD + T_RAS;
    localparam int CW   = $clog2(LONG + 1);
    localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_BST = CW'(BURST - 1);
    localparam logic [CW-1:0] L_RDA = CW'(BURST + T_RP - 1);
    localparam logic [CW-1:0] L_WRA = CW'(BURST + T_RP);
    localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_ONE = CW'(1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] rcnt;
    logic          timed;

    assign timed    = (st != BS_IDLE) && (st != BS_OPEN);
    assign ras_done = (rcnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= BS_IDLE;
            cnt  <= '0;
            rcnt <= '0;
        end else begin
            if (rcnt != '0) rcnt <= rcnt - L_ONE;
            case (op)
                OP_ACT: begin
                    st   <= BS_OPENING;
                    cnt  <= L_RCD;
                    rcnt <= L_RAS;
                end
                OP_RD:   begin st <= BS_RD;      cnt <= L_BST; end
                OP_WR:   begin st <= BS_WR;      cnt <= L_BST; end
                OP_RDA:  begin st <= BS_AUTOCL;  cnt <= L_RDA; end
                OP_WRA:  begin st <= BS_AUTOCL;  cnt <= L_WRA; end
                OP_PRE:  begin st <= BS_CLOSING; cnt <= L_RP;  end
                OP_STOP: begin st <= BS_OPEN;    cnt <= '0;    end
                default: begin
                    if (timed) begin
                        if (cnt <= L_ONE) begin
                            case (st)
                                BS_WR:                 begin st <= BS_WREC; cnt <= L_ONE; end
                                BS_CLOSING, BS_AUTOCL: st <= BS_IDLE;
                                default:               st <= BS_OPEN;
                            endcase
                        end else begin
                            cnt <= cnt - L_ONE;
                        end
                    end
                end
            endcase
        end
    end

    // R5
    autocl_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st == BS_AUTOCL) |=> (st == BS_AUTOCL || st == BS_IDLE));

    // R4
    open_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st != BS_IDLE && st != BS_OPENING) |=> (st != BS_OPENING));

    // R3
    wrec_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st == BS_WREC && op == OP_NONE) |=> (st == BS_OPEN));

    // R6
    closing_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st == BS_CLOSING && op == OP_NONE) |=> (st == BS_CLOSING || st == BS_IDLE));
endmodule

// File: rtl/sdcmd_tracker.sv
module sdcmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RP      = 3,
    parameter int T_RCD     = 3,
    parameter int T_RC      = 6,
    parameter int T_RRD     = 2,
    parameter int T_RAS     = 5,
    parameter int BURST     = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic [$clog2(NUM_BANKS)-1:0]  ba,
    input  logic                          ap,
    output logic [NUM_BANKS*3-1:0]        bank_state_o,
    output logic                          all_idle_o,
    output logic                          err_o,
    output logic [2:0]                    err_code_o
);
    localparam int BA_W  = $clog2(NUM_BANKS);
    localparam int T_MRD = 2;
    localparam int DMAX  = (T_RC > T_MRD) ? T_RC : T_MRD;
    localparam int DW    = $clog2(DMAX + 1);
    localparam int RW    = $clog2(T_RRD + 1);

    dcmd_t                      dc;
    err_t                       jerr;
    bop_t        [NUM_BANKS-1:0] op;
    bank_state_t [NUM_BANKS-1:0] st;
    logic        [NUM_BANKS-1:0] ras_done;
    logic [DW-1:0]              dev_cnt;
    logic [RW-1:0]              rrd_cnt;
    logic                       act_acc_q;
    logic                       banks_idle;
    logic                       act_acc;

    sdcmd_decode u_decode (
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ap   (ap),   .dc    (dc)
    );

    sdcmd_judge #(.NB(NUM_BANKS), .BA_W(BA_W)) u_judge (
        .dc       (dc),
        .ba       (ba),
        .st       (st),
        .ras_done (ras_done),
        .rrd_ok   (rrd_cnt == '0),
        .dev_ok   (dev_cnt == '0),
        .err      (jerr),
        .op       (op)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdcmd_bank #(.T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .BURST(BURST)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .op       (op[g]),
            .st       (st[g]),
            .ras_done (ras_done[g])
        );
        assign bank_state_o[g*3 +: 3] = st[g];
    end

    always_comb begin
        banks_idle = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++)
            if (st[b] != BS_IDLE) banks_idle = 1'b0;
    end

    assign all_idle_o = banks_idle && (dev_cnt == '0);
    assign act_acc    = (dc.cmd == CM_ACT) && (jerr == E_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_cnt    <= '0;
            rrd_cnt    <= '0;
            act_acc_q  <= 1'b0;
            err_o      <= 1'b0;
            err_code_o <= 3'd0;
        end else begin
            if (dc.cmd == CM_REF && jerr == E_NONE)      dev_cnt <= DW'(T_RC - 1);
            else if (dc.cmd == CM_MRS && jerr == E_NONE) dev_cnt <= DW'(T_MRD - 1);
            else if (dev_cnt != '0)                      dev_cnt <= dev_cnt - DW'(1);

            if (act_acc)             rrd_cnt <= RW'(T_RRD - 1);
            else if (rrd_cnt != '0)  rrd_cnt <= rrd_cnt - RW'(1);

            act_acc_q  <= act_acc;
            err_o      <= (jerr != E_NONE);
            err_code_o <= jerr;
        end
    end

    // R10
    ref_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (dc.cmd == CM_REF && !all_idle_o) |=> err_o);

    // R9
    rrd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (act_acc_q && dc.cmd == CM_ACT) |=> err_o);

    // R12
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (dc.cmd == CM_NOP) |=> !err_o);
endmodule

// File: tb/sdcmd_tracker_bench.sv
module sdcmd_tracker_bench;
    localparam int CLK_P = 10;
    localparam logic [3:0] P_NOP  = 4'b0111;
    localparam logic [3:0] P_BST  = 4'b0110;
    localparam logic [3:0] P_RD   = 4'b0101;
    localparam logic [3:0] P_WR   = 4'b0100;
    localparam logic [3:0] P_ACT  = 4'b0011;
    localparam logic [3:0] P_PRE  = 4'b0010;
    localparam logic [3:0] P_REF  = 4'b0001;
    localparam logic [3:0] P_MRS  = 4'b0000;
    localparam logic [3:0] P_DESL = 4'b1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic        ap = 1'b0;
    logic [11:0] bank_state_o;
    logic        all_idle_o, err_o;
    logic [2:0]  err_code_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sdcmd_tracker u_sdcmd_tracker (
        .clk (clk), .rst (rst), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .ba (ba), .ap (ap), .bank_state_o (bank_state_o),
        .all_idle_o (all_idle_o), .err_o (err_o), .err_code_o (err_code_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_st(input string tag, input int b, input int exp);
        chk(tag, int'(bank_state_o[b*3 +: 3]), exp);
    endtask

    task automatic chk_err(input string tag, input int code);
        chk({tag, " flag"}, int'(err_o), (code != 0) ? 1 : 0);
        chk({tag, " code"}, int'(err_code_o), code);
    endtask

    task automatic send(input logic [3:0] p, input logic [1:0] b, input logic a);
        {cs_n, ras_n, cas_n, we_n} = p;
        ba = b;
        ap = a;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
        ba = 2'd0;
        ap = 1'b0;
    endtask

    task automatic idle_n(input int n);
        repeat (n) send(P_NOP, 2'd0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        for (int b = 0; b < 4; b++) chk_st("R1 reset state", b, 0);
        chk("R1 reset all_idle", int'(all_idle_o), 1);
        chk_err("R1 reset err", 0);
    endtask

    task automatic t_open_rw_close();
        do_reset();
        send(P_ACT, 2'd0, 1'b0);   chk_st("R2 opening", 0, 1); chk_err("R2 act ok", 0);
        send(P_RD, 2'd0, 1'b0);    chk_err("R2 read too early", 1); chk_st("R2 still opening", 0, 1);
        send(P_NOP, 2'd0, 1'b0);   chk_st("R2 open after tRCD", 0, 2);
        send(P_RD, 2'd0, 1'b0);    chk_st("R3 reading", 0, 3); chk_err("R3 read ok", 0);
        idle_n(2);                 chk_st("R3 still reading", 0, 3);
        idle_n(1);                 chk_st("R3 read done", 0, 2);
        send(P_WR, 2'd0, 1'b0);    chk_st("R3 writing", 0, 4);
        idle_n(2);                 chk_st("R3 still writing", 0, 4);
        idle_n(1);                 chk_st("R3 write recovery", 0, 5);
        send(P_PRE, 2'd0, 1'b0);   chk_err("R8 precharge in recovery", 4); chk_st("R3 recovery ends", 0, 2);
        send(P_PRE, 2'd0, 1'b0);   chk_err("R6 precharge ok", 0); chk_st("R6 closing", 0, 6);
        send(P_PRE, 2'd0, 1'b0);   chk_err("R6 precharge closing bank", 0); chk_st("R6 still closing", 0, 6);
        idle_n(1);                 chk_st("R6 idle after tRP", 0, 0); chk("R6 all idle", int'(all_idle_o), 1);
    endtask

    task automatic t_act_spacing_pall();
        do_reset();
        send(P_ACT, 2'd1, 1'b0);   chk_err("R2 act b1", 0);
        send(P_ACT, 2'd2, 1'b0);   chk_err("R9 act too close", 4); chk_st("R12 b2 unchanged", 2, 0);
        send(P_ACT, 2'd1, 1'b0);   chk_err("R4 act non-idle", 2);
        send(P_ACT, 2'd2, 1'b0);   chk_err("R9 act after tRRD", 0); chk_st("R2 b2 opening", 2, 1);
        send(P_PRE, 2'd1, 1'b0);   chk_err("R8 precharge before tRAS", 4);
        send(P_PRE, 2'd2, 1'b0);   chk_err("R8 precharge b2 early", 4);
        send(P_PRE, 2'd0, 1'b1);   chk_err("R7 precharge-all blocked", 4); chk_st("R7 b1 kept open", 1, 2);
        idle_n(1);
        send(P_PRE, 2'd3, 1'b1);   chk_err("R7 precharge-all ok", 0);
        chk_st("R7 b1 closing", 1, 6); chk_st("R7 b2 closing", 2, 6);
        chk_st("R7 b0 idle", 0, 0);    chk("R7 not all idle", int'(all_idle_o), 0);
        idle_n(2);
        chk_st("R7 b1 idle", 1, 0); chk_st("R7 b2 idle", 2, 0); chk("R7 all idle", int'(all_idle_o), 1);
    endtask

    task automatic t_refresh_mode();
        do_reset();
        send(P_ACT, 2'd3, 1'b0);
        send(P_REF, 2'd0, 1'b0);   chk_err("R10 refresh with open bank", 3);
        idle_n(3);
        send(P_PRE, 2'd3, 1'b0);   chk_err("R8 precharge at tRAS", 0);
        idle_n(2);                 chk_st("R6 b3 idle", 3, 0); chk("R10 idle before refresh", int'(all_idle_o), 1);
        send(P_REF, 2'd0, 1'b0);   chk_err("R10 refresh ok", 0); chk("R10 busy window", int'(all_idle_o), 0);
        send(P_ACT, 2'd0, 1'b0);   chk_err("R10 act in refresh", 4); chk_st("R12 b0 unchanged", 0, 0);
        idle_n(3);                 chk("R10 still busy", int'(all_idle_o), 0);
        idle_n(1);                 chk("R10 refresh done", int'(all_idle_o), 1);
        send(P_MRS, 2'd0, 1'b0);   chk_err("R10 mode set ok", 0);
        send(P_ACT, 2'd0, 1'b0);   chk_err("R10 act in mode window", 4);
        send(P_ACT, 2'd0, 1'b0);   chk_err("R10 act after mode window", 0); chk_st("R10 b0 opening", 0, 1);
        send(P_MRS, 2'd0, 1'b0);   chk_err("R10 mode set with open bank", 3);
    endtask

    task automatic t_auto_precharge();
        do_reset();
        send(P_ACT, 2'd0, 1'b0);
        idle_n(2);
        send(P_RD, 2'd0, 1'b1);    chk_st("R5 read auto-close", 0, 7);
        send(P_BST, 2'd0, 1'b0);   chk_err("R5 stop during auto-close", 2);
        send(P_PRE, 2'd0, 1'b0);   chk_err("R5 precharge during auto-close", 2);
        send(P_PRE, 2'd2, 1'b1);   chk_err("R5 precharge-all during auto-close", 2);
        send(P_RD, 2'd0, 1'b0);    chk_err("R5 read during auto-close", 2);
        idle_n(1);                 chk_st("R5 read auto-close holds", 0, 7);
        idle_n(1);                 chk_st("R5 read auto-close ends", 0, 0);
        do_reset();
        send(P_ACT, 2'd1, 1'b0);
        idle_n(2);
        send(P_WR, 2'd1, 1'b1);    chk_st("R5 write auto-close", 1, 7);
        send(P_ACT, 2'd1, 1'b0);   chk_err("R5 act during auto-close", 2);
        idle_n(5);                 chk_st("R5 write auto-close holds", 1, 7);
        idle_n(1);                 chk_st("R5 write auto-close ends", 1, 0);
    endtask

    task automatic t_burst_stop();
        do_reset();
        send(P_BST, 2'd0, 1'b0);   chk_err("R11 stop with no burst", 0);
        send(P_ACT, 2'd2, 1'b0);
        idle_n(2);
        send(P_RD, 2'd2, 1'b0);    chk_st("R3 b2 reading", 2, 3);
        send(P_BST, 2'd0, 1'b0);   chk_err("R11 stop read", 0); chk_st("R11 read stopped", 2, 2);
        send(P_WR, 2'd2, 1'b0);    chk_st("R3 b2 writing", 2, 4);
        send(P_BST, 2'd1, 1'b0);   chk_st("R11 write stopped", 2, 2);
        send(P_DESL, 2'd0, 1'b0);  chk_err("R1 deselect ignored", 0); chk_st("R1 deselect no change", 2, 2);
        chk("R1 deselect not mode set", int'(all_idle_o), 0);
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_open_rw_close();
        t_act_spacing_pall();
        t_refresh_mode();
        t_auto_precharge();
        t_burst_stop();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule